// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects 64 level-sensitive interrupt request lines and presents the most urgent one to a processor. Every source has an enable bit and a 4-bit priority. A global threshold register hides all sources whose priority is not strictly above it. Among the sources that remain, the controller picks one winner. It publishes that winner as a packed vector word (source number and priority) and raises a single interrupt output while a winner exists.

Software reaches the block through a plain 32-bit register port: word address, write enable, write data and combinational read data. A source is enabled or disabled by writing its number to a dedicated register, so no read-modify-write of a mask word is needed. Two bulk registers also set or clear enables 32 at a time. A handler typically saves the threshold, raises it to the level of the source it serves, runs, and then restores it.

The winner is re-evaluated every cycle and captured in a register. The vector word and the interrupt output therefore follow the request lines, enables, priorities and threshold one clock later. Because the inputs are levels, a source that drops its line stops being presented without any acknowledge.

Top module: `prio_vector_intc`

## Requirements
- R1: After reset all enables are 0, all priorities are 0, the threshold (word 0x00) reads 0xF, `irq_o` is low and the vector word (0x07) reads 0xFFFF_FFFF.
- R2: A write of n (wdata bits 5:0) to word 0x01 sets the enable of source n, and no other enable bit changes.
- R3: A write of n (wdata bits 5:0) to word 0x02 clears the enable of source n, and no other enable bit changes.
- R4: Word 0x03 covers sources 0-31 (bit k is source k) and word 0x04 covers sources 32-63 (bit k is source 32+k). A write ORs ones into the enables, and a read returns the current enables. A 1 written to word 0x05 (sources 0-31) or 0x06 (sources 32-63) clears that enable. Zero bits leave enables unchanged in both cases.
- R5: The priority of source n lives in bits 4*(n mod 8)+3 : 4*(n mod 8) of word 0x1F - (n div 8), so words 0x18..0x1F hold the eight groups in descending address order. These words are read/write.
- R6: The threshold is bits 3:0 of word 0x00 and is readable. A source is eligible only if its priority is strictly greater than the threshold. A threshold of 0xF presents nothing.
- R7: Among sources that are active, enabled and eligible, the highest priority wins. Equal priorities go to the higher source number.
- R8: Word 0x07 reads the winner's number in bits 31:16 and its priority in bits 15:0, zero-extended. With no winner it reads all ones.
- R9: `irq_o` is high exactly when a winner exists. It and the vector word change one clock after the request line or register write that causes the change, and `irq_o` drops when the winning line drops.
- R10: Reads of words with no register (0x08..0x17, 0x20..0xFF) and of the write-only words 0x01, 0x02, 0x05, 0x06 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_src_i | input | 64 | Level interrupt requests, bit n is source n |
| addr_i | input | 8 | Register word address |
| we_i | input | 1 | Write strobe for one cycle |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
Arbitration is tried with a single active source, two equal-priority sources, a mix where a higher-priority source must beat a higher-numbered one, and sets in which the only active source is disabled. These patterns separate a correct priority compare from a plain index encoder and also expose a tie broken the wrong way. The threshold is stepped to the winner's priority and one below it, which separates a strict compare from an inclusive one. Number-based enables are applied to sources in both halves and then read back through the bulk words, which shows whether a single write disturbed any other bit. A priority planted in a middle group and reached only through arbitration confirms the descending word layout.

// File: rtl/intc_pkg.sv
package intc_pkg;

    // Register word offsets
    localparam int unsigned OFS_MASK     = 32'h00;
    localparam int unsigned OFS_EN_NUM   = 32'h01;
    localparam int unsigned OFS_DIS_NUM  = 32'h02;
    localparam int unsigned OFS_EN_LO    = 32'h03;
    localparam int unsigned OFS_EN_HI    = 32'h04;
    localparam int unsigned OFS_DIS_LO   = 32'h05;
    localparam int unsigned OFS_DIS_HI   = 32'h06;
    localparam int unsigned OFS_VEC      = 32'h07;
    localparam int unsigned OFS_PRIO_TOP = 32'h1F;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_MASK,
        OP_EN_NUM,
        OP_DIS_NUM,
        OP_EN_LO,
        OP_EN_HI,
        OP_DIS_LO,
        OP_DIS_HI,
        OP_PRIO
    } wr_op_e;

endpackage

// File: rtl/intc_cfg.sv
module intc_cfg
    import intc_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int PRIO_W  = 4,
    parameter int DATA_W  = 32,
    parameter int GRP_W   = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  wr_op_e                    op_i,
    input  logic [GRP_W-1:0]          grp_i,
    input  logic [DATA_W-1:0]         wdata_i,
    output logic [NUM_SRC-1:0]        en_o,
    output logic [NUM_SRC*PRIO_W-1:0] prio_o,
    output logic [PRIO_W-1:0]         mask_o
);
    localparam int HALF = NUM_SRC / 2;
    localparam int ID_W = $clog2(NUM_SRC);

    typedef struct packed {
        logic [NUM_SRC-1:0]        en;
        logic [NUM_SRC*PRIO_W-1:0] prio;
        logic [PRIO_W-1:0]         mask;
    } cfg_t;

    cfg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (op_i)
            OP_MASK:    st_d.mask = wdata_i[PRIO_W-1:0];
            OP_EN_NUM:  st_d.en[wdata_i[ID_W-1:0]] = 1'b1;
            OP_DIS_NUM: st_d.en[wdata_i[ID_W-1:0]] = 1'b0;
            OP_EN_LO:   st_d.en[HALF-1:0] = st_q.en[HALF-1:0] | wdata_i[HALF-1:0];
            OP_EN_HI:   st_d.en[NUM_SRC-1:HALF] = st_q.en[NUM_SRC-1:HALF] | wdata_i[HALF-1:0];
            OP_DIS_LO:  st_d.en[HALF-1:0] = st_q.en[HALF-1:0] & ~wdata_i[HALF-1:0];
            OP_DIS_HI:  st_d.en[NUM_SRC-1:HALF] = st_q.en[NUM_SRC-1:HALF] & ~wdata_i[HALF-1:0];
            OP_PRIO:    st_d.prio[int'(grp_i)*DATA_W +: DATA_W] = wdata_i;
            default:    ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.en   <= '0;
            st_q.prio <= '0;
            st_q.mask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o   = st_q.en;
    assign prio_o = st_q.prio;
    assign mask_o = st_q.mask;

endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
    parameter int NUM_SRC = 64,
    parameter int PRIO_W  = 4,
    parameter int ID_W    = 6
) (
    input  logic [NUM_SRC-1:0]        req_i,
    input  logic [NUM_SRC-1:0]        en_i,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
    input  logic [PRIO_W-1:0]         mask_i,
    output logic                      vld_o,
    output logic [ID_W-1:0]           id_o,
    output logic [PRIO_W-1:0]         pri_o
);
    localparam int NODES = 2 * NUM_SRC - 1;

    // Heap-ordered tree: node k has children 2k (lower numbers) and 2k+1.
    logic              node_vld [1:NODES];
    logic [ID_W-1:0]   node_id  [1:NODES];
    logic [PRIO_W-1:0] node_pri [1:NODES];

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_leaf
        assign node_pri[NUM_SRC+s] = prio_i[s*PRIO_W +: PRIO_W];
        assign node_id[NUM_SRC+s]  = ID_W'(s);
        assign node_vld[NUM_SRC+s] = req_i[s] && en_i[s]
                                     && (prio_i[s*PRIO_W +: PRIO_W] > mask_i);
    end

    for (genvar k = 1; k < NUM_SRC; k++) begin : g_node
        logic take_hi;
        assign take_hi = node_vld[2*k+1]
                         && (!node_vld[2*k] || (node_pri[2*k+1] >= node_pri[2*k]));
        assign node_vld[k] = node_vld[2*k] || node_vld[2*k+1];
        assign node_id[k]  = take_hi ? node_id[2*k+1]  : node_id[2*k];
        assign node_pri[k] = take_hi ? node_pri[2*k+1] : node_pri[2*k];
    end

    assign vld_o = node_vld[1];
    assign id_o  = node_id[1];
    assign pri_o = node_pri[1];

endmodule

// File: rtl/prio_vector_intc.sv
module prio_vector_intc
    import intc_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int PRIO_W  = 4,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [63:0]        irq_src_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               we_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic [DATA_W-1:0]  rdata_o,
    output logic               irq_o
);
    localparam int ID_W     = $clog2(NUM_SRC);
    localparam int PER_WORD = DATA_W / PRIO_W;
    localparam int GROUPS   = NUM_SRC / PER_WORD;
    localparam int GRP_W    = $clog2(GROUPS);
    localparam int HALF     = NUM_SRC / 2;
    localparam int FIELD_W  = DATA_W / 2;
    localparam int PRIO_LO  = int'(OFS_PRIO_TOP) - GROUPS + 1;

    typedef struct packed {
        logic              vld;
        logic [ID_W-1:0]   id;
        logic [PRIO_W-1:0] pri;
    } vec_t;

    wr_op_e                    wr_op;
    logic [GRP_W-1:0]          wr_grp;
    logic [NUM_SRC-1:0]        en_w;
    logic [NUM_SRC*PRIO_W-1:0] prio_w;
    logic [PRIO_W-1:0]         mask_w;
    logic                      arb_vld;
    logic [ID_W-1:0]           arb_id;
    logic [PRIO_W-1:0]         arb_pri;
    vec_t                      vec_d, vec_q;
    logic [ID_W-1:0]           vec_id_w;
    logic [PRIO_W-1:0]         vec_pri_w;
    int                        a_int;
    logic                      in_prio;
    logic [GRP_W-1:0]          rd_grp;

    assign a_int   = int'(addr_i);
    assign in_prio = (a_int >= PRIO_LO) && (a_int <= int'(OFS_PRIO_TOP));
    assign rd_grp  = GRP_W'(int'(OFS_PRIO_TOP) - a_int);

    // Write decode
    always_comb begin
        wr_op  = OP_NONE;
        wr_grp = rd_grp;
        if (we_i) begin
            if      (a_int == int'(OFS_MASK))    wr_op = OP_MASK;
            else if (a_int == int'(OFS_EN_NUM))  wr_op = OP_EN_NUM;
            else if (a_int == int'(OFS_DIS_NUM)) wr_op = OP_DIS_NUM;
            else if (a_int == int'(OFS_EN_LO))   wr_op = OP_EN_LO;
            else if (a_int == int'(OFS_EN_HI))   wr_op = OP_EN_HI;
            else if (a_int == int'(OFS_DIS_LO))  wr_op = OP_DIS_LO;
            else if (a_int == int'(OFS_DIS_HI))  wr_op = OP_DIS_HI;
            else if (in_prio)                    wr_op = OP_PRIO;
        end
    end

    intc_cfg #(
        .NUM_SRC (NUM_SRC),
        .PRIO_W  (PRIO_W),
        .DATA_W  (DATA_W),
        .GRP_W   (GRP_W)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_i    (wr_op),
        .grp_i   (wr_grp),
        .wdata_i (wdata_i),
        .en_o    (en_w),
        .prio_o  (prio_w),
        .mask_o  (mask_w)
    );

    intc_arbiter #(
        .NUM_SRC (NUM_SRC),
        .PRIO_W  (PRIO_W),
        .ID_W    (ID_W)
    ) u_arb (
        .req_i  (irq_src_i[NUM_SRC-1:0]),
        .en_i   (en_w),
        .prio_i (prio_w),
        .mask_i (mask_w),
        .vld_o  (arb_vld),
        .id_o   (arb_id),
        .pri_o  (arb_pri)
    );

    // Vector register
    always_comb begin
        vec_d.vld = arb_vld;
        vec_d.id  = arb_vld ? arb_id  : '0;
        vec_d.pri = arb_vld ? arb_pri : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) vec_q <= '0;
        else        vec_q <= vec_d;
    end

    assign irq_o     = vec_q.vld;
    assign vec_id_w  = vec_q.id;
    assign vec_pri_w = vec_q.pri;

    // Read mux
    always_comb begin
        rdata_o = '0;
        if      (a_int == int'(OFS_MASK))  rdata_o = DATA_W'(mask_w);
        else if (a_int == int'(OFS_EN_LO)) rdata_o = DATA_W'(en_w[HALF-1:0]);
        else if (a_int == int'(OFS_EN_HI)) rdata_o = DATA_W'(en_w[NUM_SRC-1:HALF]);
        else if (a_int == int'(OFS_VEC))
            rdata_o = vec_q.vld ? {FIELD_W'(vec_q.id), FIELD_W'(vec_q.pri)} : '1;
        else if (in_prio)
            rdata_o = prio_w[int'(rd_grp)*DATA_W +: DATA_W];
    end

endmodule

// File: rtl/intc_chk.sv
module intc_chk
    import intc_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int PRIO_W  = 4,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    parameter int ID_W    = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               we_i,
    input logic [ADDR_W-1:0]  addr_i,
    input logic [DATA_W-1:0]  wdata_i,
    input logic [63:0]        irq_src_i,
    input logic [NUM_SRC-1:0] en_w,
    input logic [PRIO_W-1:0]  mask_w,
    input logic               irq_o,
    input logic [ID_W-1:0]    vec_id_w,
    input logic [PRIO_W-1:0]  vec_pri_w
);
    logic [63:0]        src_q;
    logic [NUM_SRC-1:0] en_q;
    logic [PRIO_W-1:0]  mask_q;
    logic               en_num_wr, dis_num_wr;

    assign en_num_wr  = we_i && (int'(addr_i) == int'(OFS_EN_NUM));
    assign dis_num_wr = we_i && (int'(addr_i) == int'(OFS_DIS_NUM));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q  <= '0;
            en_q   <= '0;
            mask_q <= '1;
        end else begin
            src_q  <= irq_src_i;
            en_q   <= en_w;
            mask_q <= mask_w;
        end
    end

    // R2
    en_num_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_num_wr |=> en_w[$past(wdata_i[ID_W-1:0])]);

    // R2
    en_num_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_num_wr |=> ($countones(en_w ^ $past(en_w)) <= 1));

    // R3
    dis_num_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dis_num_wr |=> !en_w[$past(wdata_i[ID_W-1:0])]);

    // R6
    mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (vec_pri_w > mask_q));

    // R6
    full_mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '1) |-> !irq_o);

    // R9
    irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (src_q[vec_id_w] && en_q[vec_id_w]));

endmodule

bind prio_vector_intc intc_chk #(
    .NUM_SRC (NUM_SRC),
    .PRIO_W  (PRIO_W),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .ID_W    (ID_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .irq_src_i (irq_src_i),
    .en_w      (en_w),
    .mask_w    (mask_w),
    .irq_o     (irq_o),
    .vec_id_w  (vec_id_w),
    .vec_pri_w (vec_pri_w)
);

// File: tb/prio_vector_intc_bench.sv
`timescale 1ns/1ps
module prio_vector_intc_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] irq_src_i = '0;
    logic [7:0]  addr_i = '0;
    logic        we_i = 1'b0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o;
    logic        irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [63:0] en_m = '0;
    logic [3:0]  prio_m [64];
    logic [3:0]  mask_m = 4'hF;

    always #2.5 clk = ~clk;

    prio_vector_intc u_prio_vector_intc (
        .clk(clk), .rst_n(rst_n), .irq_src_i(irq_src_i), .addr_i(addr_i),
        .we_i(we_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr_i = a; wdata_i = d; we_i = 1'b1;
        @(negedge clk);
        we_i = 1'b0; wdata_i = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr_i = a;
        #1 d = rdata_o;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic en_num(input int n);
        wr(8'h01, 32'(n)); en_m[n] = 1'b1;
    endtask

    task automatic dis_num(input int n);
        wr(8'h02, 32'(n)); en_m[n] = 1'b0;
    endtask

    task automatic set_mask(input logic [3:0] m);
        wr(8'h00, {28'h0, m}); mask_m = m;
    endtask

    task automatic set_prio(input int n, input logic [3:0] p);
        logic [31:0] w;
        int g;
        prio_m[n] = p;
        g = n / 8;
        for (int k = 0; k < 8; k++) w[4*k +: 4] = prio_m[8*g + k];
        wr(8'(8'h1F - g), w);
    endtask

    function automatic logic [31:0] model_vec();
        logic found = 1'b0;
        int   best_id = 0;
        logic [3:0] best_p = '0;
        for (int s = 0; s < 64; s++) begin
            if (irq_src_i[s] && en_m[s] && prio_m[s] > mask_m
                && (!found || prio_m[s] >= best_p)) begin
                found = 1'b1; best_id = s; best_p = prio_m[s];
            end
        end
        return found ? {16'(best_id), 12'h0, best_p} : 32'hFFFF_FFFF;
    endfunction

    task automatic check_vec(input string req, input string what);
        logic [31:0] v, e;
        settle();
        e = model_vec();
        rd(8'h07, v);
        chk(req, what, v, e);
        chk(req, {what, " irq"}, {31'h0, irq_o}, {31'h0, e != 32'hFFFF_FFFF});
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(8'h00, v); chk("R1", "mask reset", v, 32'hF);
        rd(8'h03, v); chk("R1", "en lo reset", v, 32'h0);
        rd(8'h04, v); chk("R1", "en hi reset", v, 32'h0);
        for (int a = 8'h18; a <= 8'h1F; a++) begin
            rd(8'(a), v); chk("R1", "prio reset", v, 32'h0);
        end
        rd(8'h07, v); chk("R1", "vector reset", v, 32'hFFFF_FFFF);
        chk("R1", "irq reset", {31'h0, irq_o}, 32'h0);
    endtask

    task automatic t_enable_num();
        logic [31:0] v;
        en_num(5); en_num(40);
        rd(8'h03, v); chk("R2", "en lo after num", v, 32'h0000_0020);
        rd(8'h04, v); chk("R2", "en hi after num", v, 32'h0000_0100);
        dis_num(5);
        rd(8'h03, v); chk("R3", "en lo after dis", v, 32'h0);
        rd(8'h04, v); chk("R3", "en hi kept", v, 32'h0000_0100);
        dis_num(40);
    endtask

    task automatic t_bulk();
        logic [31:0] v;
        wr(8'h03, 32'hF0F0_0001); wr(8'h04, 32'h8000_0003);
        wr(8'h03, 32'h0000_0100);
        rd(8'h03, v); chk("R4", "bulk lo or", v, 32'hF0F0_0101);
        rd(8'h04, v); chk("R4", "bulk hi", v, 32'h8000_0003);
        wr(8'h05, 32'h00F0_0001); wr(8'h06, 32'h0000_0002);
        rd(8'h03, v); chk("R4", "bulk lo clear", v, 32'hF000_0100);
        rd(8'h04, v); chk("R4", "bulk hi clear", v, 32'h8000_0001);
        wr(8'h05, 32'hFFFF_FFFF); wr(8'h06, 32'hFFFF_FFFF);
        rd(8'h03, v); chk("R4", "bulk lo all clear", v, 32'h0);
        en_m = '0;
    endtask

    task automatic t_prio();
        logic [31:0] v;
        wr(8'h1F, 32'h7654_3210); wr(8'h18, 32'hFEDC_BA98);
        rd(8'h1F, v); chk("R5", "group0 word", v, 32'h7654_3210);
        rd(8'h18, v); chk("R5", "group7 word", v, 32'hFEDC_BA98);
        rd(8'h1E, v); chk("R5", "group1 untouched", v, 32'h0);
        wr(8'h1F, 32'h0); wr(8'h18, 32'h0);
        // source 9 lives in word 0x1E bits 7:4
        set_prio(9, 4'h5);
        rd(8'h1E, v); chk("R5", "src9 field", v, 32'h0000_0050);
        en_num(9); set_mask(4'h0);
        irq_src_i[9] = 1'b1;
        check_vec("R5", "src9 via arbitration");
        chk("R8", "vector packing", model_vec(), 32'h0009_0005);
    endtask

    task automatic t_mask();
        logic [31:0] v;
        set_mask(4'h5);
        rd(8'h00, v); chk("R6", "mask readback", v, 32'h5);
        check_vec("R6", "prio equal to mask hidden");
        set_mask(4'h4);
        check_vec("R6", "prio above mask shown");
        set_mask(4'hF);
        check_vec("R6", "full mask hides");
        set_mask(4'h0);
        irq_src_i[9] = 1'b0; dis_num(9); set_prio(9, 4'h0);
    endtask

    task automatic t_arb();
        set_prio(3, 4'h7); set_prio(20, 4'h7); set_prio(50, 4'h9); set_prio(63, 4'h2);
        en_num(3); en_num(20); en_num(50); en_num(63);
        irq_src_i[3] = 1'b1; irq_src_i[20] = 1'b1;
        check_vec("R7", "tie goes to higher number");
        irq_src_i[50] = 1'b1;
        check_vec("R7", "higher priority wins");
        irq_src_i[3] = 1'b0; irq_src_i[20] = 1'b0; irq_src_i[50] = 1'b0;
        irq_src_i[63] = 1'b1;
        check_vec("R8", "src63 vector");
        irq_src_i[3] = 1'b1;
        check_vec("R7", "prio 7 beats higher number 63");
        set_mask(4'h2); irq_src_i[3] = 1'b0;
        check_vec("R8", "none eligible all ones");
        irq_src_i[63] = 1'b0; irq_src_i[50] = 1'b1; dis_num(50);
        check_vec("R7", "disabled active source ignored");
        set_mask(4'h8); en_num(50);
        check_vec("R6", "prio 9 above mask 8");
        irq_src_i[50] = 1'b0;
    endtask

    task automatic t_level();
        set_mask(4'h0);
        settle();
        @(negedge clk); irq_src_i[20] = 1'b1;
        #1 chk("R9", "irq not yet high", {31'h0, irq_o}, 32'h0);
        @(negedge clk); #1 chk("R9", "irq high one clock later", {31'h0, irq_o}, 32'h1);
        @(negedge clk); irq_src_i[20] = 1'b0;
        #1 chk("R9", "irq held until edge", {31'h0, irq_o}, 32'h1);
        @(negedge clk); #1 chk("R9", "irq drops with line", {31'h0, irq_o}, 32'h0);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        int addrs [8] = '{8'h08, 8'h10, 8'h17, 8'h20, 8'hFF, 8'h01, 8'h02, 8'h05};
        wr(8'h10, 32'hDEAD_BEEF);
        foreach (addrs[i]) begin
            rd(8'(addrs[i]), v); chk("R10", "unmapped read", v, 32'h0);
        end
        rd(8'h06, v); chk("R10", "write-only read", v, 32'h0);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 64; i++) prio_m[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_enable_num();
        t_bulk();
        t_prio();
        t_mask();
        t_arb();
        t_level();
        t_unmapped();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL all watchdog: actual running expected done");
            finish_run();
        end
    end

endmodule